// File: doc/BRIEF.md
# UART receive queue with interrupt qualification

This block sits behind a UART deserializer and buffers received characters until the bus side collects them. Each stored entry keeps the character together with the three error flags that the deserializer attached to it, so the reader always learns which character was damaged. The incoming side has no back-pressure: `in_valid` is a one-cycle strobe and a character that finds the queue full is dropped. The outgoing side is valid/ready: `out_valid` is high while the queue holds an entry, `out_word` shows the oldest entry, and one entry leaves on every cycle with `out_valid` and `out_ready` both high. A read of the data register maps onto one such handshake.

Four status conditions are kept: overrun, fill level at or above a programmed threshold, a character left unread for too long, and queue not empty. Each has a mask bit, and `irq` is the OR of the status bits whose mask bits are set. The idle time is counted in character times, derived from a bit-time tick through a prescaler of `BITS_PER_CHAR` ticks. A flush control empties the queue and clears overrun and idle status together.

Top module: `rxq_irq_ctrl`

## Requirements
- R1: Accepted characters leave in arrival order; `out_word[7:0]` is the character of the oldest entry, shown while `out_valid` is high, and the queue holds up to `DEPTH` (16) entries.
- R2: Each entry keeps its own flags: `out_word[8]` break, `out_word[9]` parity error, `out_word[10]` framing error, exactly as strobed with that character.
- R3: A character strobed while the queue is full and no entry leaves in that cycle is dropped, the stored entries are unchanged, and overrun status (`irq_status[0]`) is set the next cycle.
- R4: Overrun status stays set while entries are read; reading does not clear it.
- R5: A cycle with `fifo_flush` high empties the queue, clears overrun and idle status, and drops any character strobed or read in that cycle.
- R6: Threshold status (`irq_status[1]`) is high exactly while `fill_level` is at or above `thr_level`.
- R7: Idle status (`irq_status[2]`) rises once the queue is non-empty and `idle_limit` (nonzero) character times of `BITS_PER_CHAR` bit ticks pass with no push or pop; a push or pop restarts the count and clears the status.
- R8: Not-empty status (`irq_status[3]`) is high exactly while the queue holds at least one entry.
- R9: `irq` is high exactly when some `irq_status` bit is high whose `irq_mask` bit (same position: 0 overrun, 1 threshold, 2 idle, 3 not-empty) is set.
- R10: With the queue full, a strobe in the same cycle as a read is accepted: the level stays at `DEPTH`, no overrun is raised, and order is kept.
- R11: After reset the queue is empty, all status bits are low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: a received character is present |
| in_char | input | 8 | Received character |
| in_brk | input | 1 | Break detected with this character |
| in_perr | input | 1 | Parity error on this character |
| in_ferr | input | 1 | Framing error on this character |
| bit_tick | input | 1 | One pulse per serial bit time |
| out_valid | output | 1 | Queue holds an entry |
| out_ready | input | 1 | Reader takes the shown entry |
| out_word | output | 11 | Oldest entry: flags in 10:8, character in 7:0 |
| fifo_flush | input | 1 | Empty queue, clear overrun and idle status |
| thr_level | input | 5 | Fill threshold |
| idle_limit | input | 4 | Idle limit in character times, 0 disables |
| irq_mask | input | 4 | Per-status interrupt enables |
| irq_status | output | 4 | Status: 0 overrun, 1 threshold, 2 idle, 3 not-empty |
| fill_level | output | 5 | Number of stored entries |
| irq | output | 1 | Interrupt request |

## Verification
The collision of interest is a character arriving in the same cycle as a read while the queue is full: the write must use the slot the read frees, so the level holds at sixteen and overrun stays low. The bench fills the queue, then drives `in_valid` and `out_ready` in one cycle and judges it by the overrun bit, the level, and the order of all sixteen words drained afterwards. A second collision, flush together with a strobe, is judged by an empty queue with cleared status.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Entry layout: flags above the character; the reader decodes these bits.
  typedef struct packed {
    logic       ferr;
    logic       perr;
    logic       brk;
    logic [7:0] ch;
  } rxq_word_t;

  localparam int WORD_W = $bits(rxq_word_t);

  // Status bit positions; shared with the mask.
  localparam int ST_OVR  = 0;
  localparam int ST_THR  = 1;
  localparam int ST_IDLE = 2;
  localparam int ST_NE   = 3;
  localparam int ST_W    = 4;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            wr_en,
  input  rxq_word_t       wr_word,
  input  logic            rd_en,
  output rxq_word_t       rd_word,
  output logic [LW-1:0]   level,
  output logic            empty,
  output logic            full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  rxq_word_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_word = mem[rd_ptr];
  assign level   = cnt;
  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_LVL);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int BITS_PER_CHAR = 10,
  parameter int LIM_W = 4,
  localparam int BW = (BITS_PER_CHAR > 1) ? $clog2(BITS_PER_CHAR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold,
  input  logic             bit_tick,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);
  localparam logic [BW-1:0]    BIT_LAST = BW'(BITS_PER_CHAR - 1);
  localparam logic [LIM_W-1:0] CHAR_MAX = '1;

  logic [BW-1:0]    bit_cnt;
  logic [LIM_W-1:0] char_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      char_cnt <= '0;
    end else if (restart || hold) begin
      bit_cnt  <= '0;
      char_cnt <= '0;
    end else if (bit_tick) begin
      if (bit_cnt == BIT_LAST) begin
        bit_cnt <= '0;
        if (char_cnt != CHAR_MAX) char_cnt <= char_cnt + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign expired = (limit != '0) && (char_cnt >= limit);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            drop,
  input  logic [LW-1:0]   level,
  input  logic [LW-1:0]   thr,
  input  logic            idle_hit,
  input  logic            empty,
  input  logic [ST_W-1:0] mask,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ovr_q <= 1'b0;
    else if (flush) ovr_q <= 1'b0;
    else if (drop)  ovr_q <= 1'b1;
  end

  always_comb begin
    status          = '0;
    status[ST_OVR]  = ovr_q;
    status[ST_THR]  = (level >= thr);
    status[ST_IDLE] = idle_hit && !empty;
    status[ST_NE]   = !empty;
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int LIM_W = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  input  logic              in_brk,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              bit_tick,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  input  logic              fifo_flush,
  input  logic [LW-1:0]     thr_level,
  input  logic [LIM_W-1:0]  idle_limit,
  input  logic [ST_W-1:0]   irq_mask,
  output logic [ST_W-1:0]   irq_status,
  output logic [LW-1:0]     fill_level,
  output logic              irq
);
  rxq_word_t     wr_word, rd_word;
  logic          empty, full, pop, push, drop, idle_hit;
  logic [LW-1:0] level;

  assign wr_word = '{ferr: in_ferr, perr: in_perr, brk: in_brk, ch: in_char};

  // A read frees a slot in the same cycle, so a full queue still takes a write.
  assign pop  = out_ready && !empty && !fifo_flush;
  assign push = in_valid && !fifo_flush && (!full || pop);
  assign drop = in_valid && !fifo_flush && full && !pop;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (fifo_flush),
    .wr_en   (push),
    .wr_word (wr_word),
    .rd_en   (pop),
    .rd_word (rd_word),
    .level   (level),
    .empty   (empty),
    .full    (full)
  );

  rxq_idle_timer #(.BITS_PER_CHAR(BITS_PER_CHAR), .LIM_W(LIM_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (push || pop || fifo_flush),
    .hold     (empty),
    .bit_tick (bit_tick),
    .limit    (idle_limit),
    .expired  (idle_hit)
  );

  rxq_status #(.LW(LW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (fifo_flush),
    .drop     (drop),
    .level    (level),
    .thr      (thr_level),
    .idle_hit (idle_hit),
    .empty    (empty),
    .mask     (irq_mask),
    .status   (irq_status),
    .irq      (irq)
  );

  assign out_valid  = !empty;
  assign out_word   = rd_word;
  assign fill_level = level;
endmodule

// File: rtl/rxq_irq_chk.sv
module rxq_irq_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_ready,
  input logic          out_valid,
  input logic          fifo_flush,
  input logic [LW-1:0] thr_level,
  input logic [3:0]    irq_status,
  input logic [LW-1:0] fill_level
);
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == LW'(DEPTH) && in_valid && !out_ready && !fifo_flush)
      |=> (irq_status[0] && fill_level == LW'(DEPTH)));

  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[0] && !fifo_flush) |=> irq_status[0]);

  a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (!out_valid && !irq_status[0] && !irq_status[2]
                    && fill_level == '0));

  a_r6_thr_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[1]) |-> (fill_level >= thr_level));

  a_r7_idle_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[2] |-> out_valid);

  a_r8_ne_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[3] |-> (fill_level != '0));

  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == LW'(DEPTH) && in_valid && out_ready && !fifo_flush
     && !irq_status[0])
      |=> (!irq_status[0] && fill_level == LW'(DEPTH)));
endmodule

bind rxq_irq_ctrl rxq_irq_chk #(.DEPTH(DEPTH)) u_rxq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .fifo_flush (fifo_flush),
  .thr_level  (thr_level),
  .irq_status (irq_status),
  .fill_level (fill_level)
);

// File: tb/rxq_irq_ctrl_test.sv
module rxq_irq_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int DEPTH = 16;
  localparam int BPC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = '0;
  logic        in_brk = 1'b0, in_perr = 1'b0, in_ferr = 1'b0;
  logic        bit_tick = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [10:0] out_word;
  logic        fifo_flush = 1'b0;
  logic [4:0]  thr_level = 5'd8;
  logic [3:0]  idle_limit = 4'd1;
  logic [3:0]  irq_mask = 4'd0;
  logic [3:0]  irq_status;
  logic [4:0]  fill_level;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit summary_done = 1'b0;
  logic [10:0] sb[$];

  always #(CLK_NS/2) clk = ~clk;

  rxq_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .in_brk(in_brk), .in_perr(in_perr), .in_ferr(in_ferr),
    .bit_tick(bit_tick), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .fifo_flush(fifo_flush), .thr_level(thr_level),
    .idle_limit(idle_limit), .irq_mask(irq_mask), .irq_status(irq_status),
    .fill_level(fill_level), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // Driver: strobe one character and record what the queue should hold.
  task automatic push(input logic [7:0] c, input logic b, input logic p,
                      input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_char = c; in_brk = b; in_perr = p; in_ferr = f;
    if (sb.size() < DEPTH) sb.push_back({f, p, b, c});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare the shown word with the scoreboard head, then take it.
  task automatic pop_cmp(input string tag);
    logic [10:0] e;
    @(negedge clk);
    e = sb.pop_front();
    chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
    chk({tag, " word"}, 32'(out_word), 32'(e));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    fifo_flush = 1'b1;
    @(negedge clk);
    fifo_flush = 1'b0;
    sb.delete();
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    bit_tick = 1'b1;
    repeat (n) @(negedge clk);
    bit_tick = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 status", 32'(irq_status), 32'h0);
    chk("R11 valid", 32'(out_valid), 32'h0);
    chk("R11 level", 32'(fill_level), 32'h0);
    irq_mask = 4'hF;
    @(negedge clk);
    chk("R11 irq", 32'(irq), 32'h0);
    irq_mask = 4'h0;

    // R1 R2 order and flags
    push(8'h41, 1'b0, 1'b0, 1'b0);
    push(8'h42, 1'b1, 1'b0, 1'b0);
    push(8'h43, 1'b0, 1'b1, 1'b0);
    push(8'h44, 1'b0, 1'b0, 1'b1);
    chk("R8 ne set", 32'(irq_status[3]), 32'd1);
    chk("R1 level", 32'(fill_level), 32'd4);
    pop_cmp("R1 first");
    pop_cmp("R2 brk");
    pop_cmp("R2 perr");
    pop_cmp("R2 ferr");
    @(negedge clk);
    chk("R8 ne clear", 32'(irq_status[3]), 32'd0);

    // R3 R4 overrun
    for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i), i[0], i[1], i[2]);
    chk("R1 full level", 32'(fill_level), 32'd16);
    chk("R3 no ovr yet", 32'(irq_status[0]), 32'd0);
    push(8'hEE, 1'b1, 1'b1, 1'b1);
    chk("R3 ovr set", 32'(irq_status[0]), 32'd1);
    chk("R3 level kept", 32'(fill_level), 32'd16);
    for (int i = 0; i < DEPTH; i++) pop_cmp("R3 kept");
    @(negedge clk);
    chk("R4 ovr after reads", 32'(irq_status[0]), 32'd1);
    irq_mask = 4'b0001;
    @(negedge clk);
    chk("R9 ovr irq", 32'(irq), 32'd1);
    irq_mask = 4'h0;
    flush();
    chk("R5 ovr cleared", 32'(irq_status[0]), 32'd0);

    // R6 threshold, R9 mask
    for (int i = 0; i < 7; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    chk("R6 below", 32'(irq_status[1]), 32'd0);
    push(8'h07, 1'b0, 1'b0, 1'b0);
    chk("R6 at thr", 32'(irq_status[1]), 32'd1);
    irq_mask = 4'b0001;
    @(negedge clk);
    chk("R9 masked out", 32'(irq), 32'd0);
    irq_mask = 4'b0010;
    @(negedge clk);
    chk("R9 thr irq", 32'(irq), 32'd1);
    irq_mask = 4'b1000;
    @(negedge clk);
    chk("R9 ne irq", 32'(irq), 32'd1);
    irq_mask = 4'h0;
    pop_cmp("R6 pop");
    chk("R6 dropped below", 32'(irq_status[1]), 32'd0);

    // R5 flush with a strobe in the same cycle
    @(negedge clk);
    fifo_flush = 1'b1; in_valid = 1'b1; in_char = 8'h99;
    @(negedge clk);
    fifo_flush = 1'b0; in_valid = 1'b0;
    sb.delete();
    chk("R5 empty", 32'(fill_level), 32'd0);
    chk("R5 no valid", 32'(out_valid), 32'd0);

    // R7 idle timeout
    ticks(BPC + 2);
    chk("R7 empty no idle", 32'(irq_status[2]), 32'd0);
    push(8'h5A, 1'b0, 1'b0, 1'b0);
    ticks(BPC - 1);
    chk("R7 before limit", 32'(irq_status[2]), 32'd0);
    ticks(1);
    chk("R7 at limit", 32'(irq_status[2]), 32'd1);
    push(8'h5B, 1'b0, 1'b0, 1'b0);
    chk("R7 push restarts", 32'(irq_status[2]), 32'd0);
    idle_limit = 4'd2;
    ticks(BPC);
    chk("R7 limit2 one char", 32'(irq_status[2]), 32'd0);
    ticks(BPC);
    chk("R7 limit2 two chars", 32'(irq_status[2]), 32'd1);
    flush();
    chk("R5 idle cleared", 32'(irq_status[2]), 32'd0);
    idle_limit = 4'd1;

    // R10 full queue, strobe and read in the same cycle
    for (int i = 0; i < DEPTH; i++) push(8'(8'hA0 + i), 1'b0, i[0], 1'b0);
    @(negedge clk);
    chk("R10 head", 32'(out_word), 32'(sb[0]));
    in_valid = 1'b1; in_char = 8'hC3; in_brk = 1'b1; in_perr = 1'b0;
    in_ferr = 1'b1; out_ready = 1'b1;
    void'(sb.pop_front());
    sb.push_back({1'b1, 1'b0, 1'b1, 8'hC3});
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk("R10 no ovr", 32'(irq_status[0]), 32'd0);
    chk("R10 level", 32'(fill_level), 32'd16);
    for (int i = 0; i < DEPTH; i++) pop_cmp("R10 order");
    chk("R10 drained", 32'(out_valid), 32'd0);

    report();
    $finish;
  end
endmodule